// File: doc/BRIEF.md
# Byte-Wide to Double-Data-Rate Nibble Ethernet Adapter

This block sits between a MAC that works with an 8-bit, single-edge byte stream and a gigabit PHY that uses a 4-bit, double-data-rate pin interface. On the transmit side, a byte and its enable/error pair are accepted on every rising edge of the 125 MHz transmit clock. Each byte leaves as two nibbles on four data lines: the low nibble while the clock is high and the high nibble while it is low. A single control line carries the enable in the high phase and the error flag in the low phase. The transmit clock is forwarded to the pins unchanged.

On the receive side, the block samples the four data lines and the control line on both edges of the PHY's receive clock. Each rising-edge sample is paired with the falling-edge sample that follows it. Once per receive clock cycle, the block presents a whole byte with its valid and error flags, registered on the rising edge. The DDR stages are behavioural flip-flops on both clock edges, so the block needs no technology cells.

Both directions are plain streams with no back-pressure. The byte side has no ready signal: the adapter takes or delivers one byte in every clock cycle, and `tx_en` and `rx_dv` act as the valid qualifiers. A source that cannot keep pace must de-assert its enable, which sends an idle symbol.

Top module: `rgmii_gmii_adapter`

## Requirements
- R1: While `tx_rst_n` is low, `rgmii_txd` and `rgmii_tx_ctl` are 0 in both clock phases. While `rx_rst_n` is low, `rx_data`, `rx_dv` and `rx_er` are 0.
- R2: The byte side is sampled on the rising edge of `tx_clk`. During the high phase that follows that edge, `rgmii_txd` equals bits 3:0 of the sampled byte and `rgmii_tx_ctl` equals the sampled `tx_en`.
- R3: During the low phase of the same cycle, `rgmii_txd` equals bits 7:4 of that same byte and `rgmii_tx_ctl` equals the sampled `tx_er`.
- R4: When `tx_en` is sampled low, `rgmii_txd` is 0 and `rgmii_tx_ctl` is low in both phases of that cycle, whatever `tx_data` and `tx_er` hold.
- R5: `rgmii_txc` follows `tx_clk`: it is high in the high phase and low in the low phase.
- R6: Let a rising edge k of `rgmii_rxc` capture the low nibble and the valid flag, and the next falling edge capture the high nibble and the error flag. After rising edge k+1, `rx_data` holds {high nibble, low nibble}, `rx_dv` holds the valid flag and `rx_er` holds the error flag.
- R7: Whenever `rx_dv` is low, `rx_data` is 0. `rx_er` still reports the error flag captured on the falling edge.
- R8: Back-to-back bytes stream in both directions at one byte per clock cycle with no stall, and their order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock, 125 MHz in service |
| tx_rst_n | input | 1 | Asynchronous active-low reset, transmit domain |
| tx_data | input | 8 | Byte to send |
| tx_en | input | 1 | Byte valid / frame in progress |
| tx_er | input | 1 | Transmit error flag |
| rgmii_txc | output | 1 | Forwarded transmit clock |
| rgmii_txd | output | 4 | DDR transmit nibbles |
| rgmii_tx_ctl | output | 1 | DDR enable (high phase) / error (low phase) |
| rgmii_rxc | input | 1 | Receive clock from the PHY |
| rx_rst_n | input | 1 | Asynchronous active-low reset, receive domain |
| rgmii_rxd | input | 4 | DDR receive nibbles |
| rgmii_rx_ctl | input | 1 | DDR valid (rising) / error (falling) |
| rx_data | output | 8 | Reassembled byte |
| rx_dv | output | 1 | Byte valid |
| rx_er | output | 1 | Receive error flag |

## Verification
The bench builds the adapter with its default byte width of 8, which is the width the pin format fixes. With that width, every bit of both nibbles appears on a distinct pin value. Nibble patterns such as 0xA5, 0x3C and a counting sequence expose swapped or shifted halves. The bench ties the receive clock to the transmit clock, so one clock advances both directions. It then drives the pin side in the middle of each phase, which puts the pairing of a rising capture with the next falling capture within reach of exact cycle checks.

// File: rtl/rgmii_ddr_pkg.sv
package rgmii_ddr_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic en;
    logic er;
  } ctl_pair_t;
endpackage

// File: rtl/rgmii_ddr_tx.sv
module rgmii_ddr_tx
  import rgmii_ddr_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   data,
  input  logic                en,
  input  logic                er,
  output logic [DATA_W/2-1:0] txd,
  output logic                tx_ctl
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] byte_q;
  ctl_pair_t         ctl_q;
  logic [NIB_W-1:0]  hi_q;
  logic              er_fall_q;

  // rising edge: take the whole byte so both halves come from one sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      ctl_q  <= '0;
    end else begin
      byte_q   <= en ? data : '0;
      ctl_q.en <= en;
      ctl_q.er <= en & er;
    end
  end

  // falling edge: stage the upper half of the byte held since the rise
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      er_fall_q <= 1'b0;
    end else begin
      hi_q      <= byte_q[DATA_W-1:NIB_W];
      er_fall_q <= ctl_q.er;
    end
  end

  // behavioural DDR output select
  assign txd    = clk ? byte_q[NIB_W-1:0] : hi_q;
  assign tx_ctl = clk ? ctl_q.en : er_fall_q;

  logic started_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && !$past(en)) |-> (byte_q == '0 && !ctl_q.er && !ctl_q.en));

  assert_half_same_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (hi_q == byte_q[DATA_W-1:NIB_W] && er_fall_q == ctl_q.er));

  assert_enable_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (ctl_q.en == $past(en)));
endmodule

// File: rtl/rgmii_ddr_rx.sv
module rgmii_ddr_rx
  import rgmii_ddr_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                rxc,
  input  logic                rst_n,
  input  logic [DATA_W/2-1:0] rxd,
  input  logic                rx_ctl,
  output logic [DATA_W-1:0]   data,
  output logic                dv,
  output logic                er
);
  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0] lo_rise_q;
  logic [NIB_W-1:0] hi_fall_q;
  ctl_pair_t        cap_q;

  // falling edge: upper half and error flag
  always_ff @(negedge rxc or negedge rst_n) begin
    if (!rst_n) begin
      hi_fall_q <= '0;
      cap_q.er  <= 1'b0;
    end else begin
      hi_fall_q <= rxd;
      cap_q.er  <= rx_ctl;
    end
  end

  // rising edge: lower half and valid, then assemble the previous pair
  always_ff @(posedge rxc or negedge rst_n) begin
    if (!rst_n) begin
      lo_rise_q <= '0;
      cap_q.en  <= 1'b0;
      data      <= '0;
      dv        <= 1'b0;
      er        <= 1'b0;
    end else begin
      lo_rise_q <= rxd;
      cap_q.en  <= rx_ctl;
      data      <= cap_q.en ? {hi_fall_q, lo_rise_q} : '0;
      dv        <= cap_q.en;
      er        <= cap_q.er;
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge rxc or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 2) age_q <= age_q + 2'd1;
  end

  assert_quiet_data_R7: assert property (@(posedge rxc) disable iff (!rst_n)
    !dv |-> (data == '0));

  assert_valid_latency_R6: assert property (@(posedge rxc) disable iff (!rst_n)
    (age_q == 2) |-> (dv == $past(rx_ctl, 2)));
endmodule

// File: rtl/rgmii_gmii_adapter.sv
module rgmii_gmii_adapter
  import rgmii_ddr_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                tx_clk,
  input  logic                tx_rst_n,
  input  logic [DATA_W-1:0]   tx_data,
  input  logic                tx_en,
  input  logic                tx_er,
  output logic                rgmii_txc,
  output logic [DATA_W/2-1:0] rgmii_txd,
  output logic                rgmii_tx_ctl,
  input  logic                rgmii_rxc,
  input  logic                rx_rst_n,
  input  logic [DATA_W/2-1:0] rgmii_rxd,
  input  logic                rgmii_rx_ctl,
  output logic [DATA_W-1:0]   rx_data,
  output logic                rx_dv,
  output logic                rx_er
);
  assign rgmii_txc = tx_clk;

  rgmii_ddr_tx #(.DATA_W(DATA_W)) u_tx (
    .clk    (tx_clk),
    .rst_n  (tx_rst_n),
    .data   (tx_data),
    .en     (tx_en),
    .er     (tx_er),
    .txd    (rgmii_txd),
    .tx_ctl (rgmii_tx_ctl)
  );

  rgmii_ddr_rx #(.DATA_W(DATA_W)) u_rx (
    .rxc    (rgmii_rxc),
    .rst_n  (rx_rst_n),
    .rxd    (rgmii_rxd),
    .rx_ctl (rgmii_rx_ctl),
    .data   (rx_data),
    .dv     (rx_dv),
    .er     (rx_er)
  );

  assert_idle_pins_R1: assert property (@(posedge tx_clk)
    !tx_rst_n |-> (rgmii_txd == '0 && !rgmii_tx_ctl));
endmodule

// File: tb/rgmii_gmii_adapter_bench.sv
`timescale 1ns/10ps
module rgmii_gmii_adapter_bench;
  logic       clk = 1'b0;
  logic       tx_rst_n = 1'b0, rx_rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic       rgmii_txc;
  logic [3:0] rgmii_txd;
  logic       rgmii_tx_ctl;
  logic [3:0] rgmii_rxd = '0;
  logic       rgmii_rx_ctl = 1'b0;
  logic [7:0] rx_data;
  logic       rx_dv, rx_er;

  always #2.5 clk = ~clk;

  rgmii_gmii_adapter u_rgmii_gmii_adapter (
    .tx_clk(clk), .tx_rst_n(tx_rst_n), .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er),
    .rgmii_txc(rgmii_txc), .rgmii_txd(rgmii_txd), .rgmii_tx_ctl(rgmii_tx_ctl),
    .rgmii_rxc(clk), .rx_rst_n(rx_rst_n), .rgmii_rxd(rgmii_rxd), .rgmii_rx_ctl(rgmii_rx_ctl),
    .rx_data(rx_data), .rx_dv(rx_dv), .rx_er(rx_er)
  );

  int tests = 0, fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { logic [3:0] lo, hi; logic c_r, c_f; } tx_exp_t;
  typedef struct { logic [7:0] d; logic dv, er; } rx_exp_t;
  tx_exp_t txq[$];
  rx_exp_t rxq[$];

  task automatic tx_send(input logic [7:0] d, input logic en, input logic er);
    tx_exp_t e;
    @(negedge clk);
    tx_data = d; tx_en = en; tx_er = er;
    e.lo = en ? d[3:0] : 4'h0;
    e.hi = en ? d[7:4] : 4'h0;
    e.c_r = en;
    e.c_f = en & er;
    txq.push_back(e);
  endtask

  task automatic rx_send(input logic [7:0] d, input logic dv, input logic er);
    rx_exp_t e;
    @(negedge clk); #1.25;
    rgmii_rxd = d[3:0]; rgmii_rx_ctl = dv;
    @(posedge clk); #1.25;
    rgmii_rxd = d[7:4]; rgmii_rx_ctl = er;
    e.d = dv ? d : 8'h00;
    e.dv = dv;
    e.er = er;
    rxq.push_back(e);
  endtask

  // transmit monitor: high phase then low phase of each cycle
  tx_exp_t tm;
  always @(posedge clk) begin
    if (txq.size() > 0) begin
      tm = txq[0];
      #1;
      check("R2 txd high phase", rgmii_txd, tm.lo);
      check("R2 tx_ctl high phase (R4 when idle)", rgmii_tx_ctl, tm.c_r);
      check("R5 txc high", rgmii_txc, 1);
      @(negedge clk); #1;
      check("R3 txd low phase (R8 order)", rgmii_txd, tm.hi);
      check("R3 tx_ctl low phase (R4 when idle)", rgmii_tx_ctl, tm.c_f);
      check("R5 txc low", rgmii_txc, 0);
      void'(txq.pop_front());
    end
  end

  // receive monitor: result appears one rising edge after the pair completes
  rx_exp_t rm;
  always @(posedge clk) begin
    if (rxq.size() > 0) begin
      rm = rxq[0];
      #1;
      check("R6 rx_data (R7 zero when invalid, R8 order)", rx_data, rm.d);
      check("R6 rx_dv", rx_dv, rm.dv);
      check("R6 R7 rx_er", rx_er, rm.er);
      void'(rxq.pop_front());
    end
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tx_data = 8'hFF; tx_en = 1'b1; tx_er = 1'b1;
    rgmii_rxd = 4'hF; rgmii_rx_ctl = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 txd in reset high", rgmii_txd, 0);
    check("R1 tx_ctl in reset high", rgmii_tx_ctl, 0);
    check("R1 rx_data in reset", rx_data, 0);
    check("R1 rx_dv in reset", rx_dv, 0);
    check("R1 rx_er in reset", rx_er, 0);
    @(negedge clk); #1;
    check("R1 txd in reset low", rgmii_txd, 0);
    check("R1 tx_ctl in reset low", rgmii_tx_ctl, 0);
    tx_en = 1'b0; tx_er = 1'b0; rgmii_rx_ctl = 1'b0; rgmii_rxd = '0;
    @(negedge clk);
    tx_rst_n = 1'b1; rx_rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // transmit patterns
    tx_send(8'hA5, 1, 0);
    tx_send(8'h3C, 1, 1);
    tx_send(8'hFF, 0, 1);
    tx_send(8'h96, 0, 0);
    for (int i = 0; i < 12; i++) tx_send(8'(i * 8'h13 + 8'h21), 1, (i % 5) == 0);
    tx_send(8'h00, 0, 0);
    tx_send(8'h00, 0, 0);
    repeat (4) @(posedge clk);

    // receive patterns
    rx_send(8'h5A, 1, 0);
    rx_send(8'hC3, 1, 1);
    rx_send(8'h77, 0, 1);
    rx_send(8'hE8, 0, 0);
    for (int i = 0; i < 12; i++) rx_send(8'(i * 8'h29 + 8'h07), 1, (i % 4) == 3);
    rx_send(8'h00, 0, 0);
    rx_send(8'h00, 0, 0);
    repeat (6) @(posedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule